// File: doc/BRIEF.md
# Memory-mapped device register decoder

This block sits between a processor's single-port load/store interface and the storage behind it: a small word-addressed data memory and two 32-bit device registers. Every cycle it looks at the address and the write strobe. Two fixed words near the top of the address space belong to the devices. Every other address falls through to the memory.

A store to a device word loads that device's register on the next clock edge. That store never reaches the memory. The block also drives a two-bit code that picks the source of load data: memory, device one or device two. Load data is combinational from the address. Each access completes in the cycle it is presented, so there is no valid/ready handshake and no back-pressure. The processor may present a new address every cycle. The contents of both device registers are brought out as plain outputs.

Top module: `mmio_bridge`

## Requirements
- R1: While reset is held and right after it is released, both device register outputs read zero.
- R2: A store (write strobe high) to address 0xFFFFFFF4 loads device one's register at the next rising clock edge. The memory word that the address bits 7:2 would select is left unchanged.
- R3: A store to address 0xFFFFFFF8 loads device two's register at the next rising clock edge. The memory word selected by address bits 7:2 is left unchanged.
- R4: A store to any other address writes the memory word indexed by address bits 7:2 and leaves both device registers unchanged.
- R5: With the write strobe low, no memory word and no device register changes, whatever the address and write data are.
- R6: The read-select output is 00 for a memory address, 01 for 0xFFFFFFF4 and 10 for 0xFFFFFFF8. The code 11 never appears. If the internal multiplexer ever received it, the load data would be zero.
- R7: Load data equals the selected source in the same cycle the address is presented: memory word, device one's register or device two's register.
- R8: Memory addresses alias modulo 256 bytes. Only bits 7:2 pick one of the 64 words, and byte-offset bits 1:0 are ignored.
- R9: At most one of the three internal write enables (memory, device one, device two) is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset of the device registers |
| cpu_addr | input | 32 | Byte address of the load or store |
| cpu_we | input | 1 | Store strobe, high for one cycle per store |
| cpu_wdata | input | 32 | Store data |
| cpu_rdata | output | 32 | Load data from the selected source |
| rd_sel | output | 2 | Read-source code: 00 memory, 01 device one, 10 device two |
| dev1_q | output | 32 | Device one register contents |
| dev2_q | output | 32 | Device two register contents |

## Verification
The bench builds the block with its default parameters: 32-bit data and addresses, a 64-word memory, and device words at 0xFFFFFFF4 and 0xFFFFFFF8.

With these values the memory's 256-byte wrap can be reached in a few accesses. The device addresses alias onto memory words 61 and 62, so the bench can pre-load exactly the words a misrouted store would damage. Address 0xFFFFFFFC shares the device words' upper bits but is not a device word, which makes it a useful near-miss for the decoder.

// File: rtl/mmio_pkg.sv
package mmio_pkg;
  typedef enum logic [1:0] {
    SRC_MEM  = 2'b00,
    SRC_DEV1 = 2'b01,
    SRC_DEV2 = 2'b10
  } rd_src_e;
endpackage

// File: rtl/mmio_addr_decode.sv
module mmio_addr_decode
  import mmio_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter logic [ADDR_W-1:0] DEV1_ADDR = 32'hFFFF_FFF4,
  parameter logic [ADDR_W-1:0] DEV2_ADDR = 32'hFFFF_FFF8
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  output logic              mem_we,
  output logic [1:0]        dev_we,
  output rd_src_e           src
);
  localparam int NDEV = 2;
  localparam logic [ADDR_W-1:0] DEV_ADDRS [NDEV] = '{DEV1_ADDR, DEV2_ADDR};

  logic [NDEV-1:0] hit;

  for (genvar d = 0; d < NDEV; d++) begin : g_hit
    assign hit[d]    = (addr == DEV_ADDRS[d]);
    assign dev_we[d] = we && hit[d];
  end

  assign mem_we = we && (hit == '0);

  always_comb begin
    unique case (1'b1)
      hit[0]:  src = SRC_DEV1;
      hit[1]:  src = SRC_DEV2;
      default: src = SRC_MEM;
    endcase
  end
endmodule

// File: rtl/mmio_word_mem.sv
module mmio_word_mem #(
  parameter int DATA_W = 32,
  parameter int WORDS  = 64
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [$clog2(WORDS)-1:0] idx,
  input  logic [DATA_W-1:0]        wdata,
  output logic [DATA_W-1:0]        rdata
);
  logic [DATA_W-1:0] store_q [WORDS];

  always_ff @(posedge clk) begin
    if (we) store_q[idx] <= wdata;
  end

  assign rdata = store_q[idx];
endmodule

// File: rtl/mmio_dev_reg.sv
module mmio_dev_reg #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [DATA_W-1:0] d,
  output logic [DATA_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n)  q <= '0;
    else if (we) q <= d;
  end

  // R2 / R3: a strobed store is captured on the next edge
  a_r2_capture: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (q == $past(d)));
  // R5: without a strobe the register holds
  a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(q));
endmodule

// File: rtl/mmio_rdata_mux.sv
module mmio_rdata_mux
  import mmio_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  rd_src_e           src,
  input  logic [DATA_W-1:0] mem_d,
  input  logic [DATA_W-1:0] dev1_d,
  input  logic [DATA_W-1:0] dev2_d,
  output logic [DATA_W-1:0] y
);
  always_comb begin
    case (src)
      SRC_MEM:  y = mem_d;
      SRC_DEV1: y = dev1_d;
      SRC_DEV2: y = dev2_d;
      default:  y = '0;
    endcase
  end
endmodule

// File: rtl/mmio_bridge.sv
module mmio_bridge
  import mmio_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 32,
  parameter int MEM_WORDS = 64,
  parameter logic [ADDR_W-1:0] DEV1_ADDR = 32'hFFFF_FFF4,
  parameter logic [ADDR_W-1:0] DEV2_ADDR = 32'hFFFF_FFF8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic              cpu_we,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic [1:0]        rd_sel,
  output logic [DATA_W-1:0] dev1_q,
  output logic [DATA_W-1:0] dev2_q
);
  localparam int IDX_W = $clog2(MEM_WORDS);
  localparam int NDEV  = 2;

  logic              mem_we;
  logic [NDEV-1:0]   dev_we;
  rd_src_e           src;
  logic [DATA_W-1:0] mem_rd;
  logic [DATA_W-1:0] dev_q [NDEV];

  mmio_addr_decode #(
    .ADDR_W(ADDR_W), .DEV1_ADDR(DEV1_ADDR), .DEV2_ADDR(DEV2_ADDR)
  ) u_dec (
    .addr(cpu_addr), .we(cpu_we), .mem_we(mem_we), .dev_we(dev_we), .src(src)
  );

  mmio_word_mem #(.DATA_W(DATA_W), .WORDS(MEM_WORDS)) u_mem (
    .clk(clk), .we(mem_we), .idx(cpu_addr[IDX_W+1:2]),
    .wdata(cpu_wdata), .rdata(mem_rd)
  );

  for (genvar d = 0; d < NDEV; d++) begin : g_dev
    mmio_dev_reg #(.DATA_W(DATA_W)) u_reg (
      .clk(clk), .rst_n(rst_n), .we(dev_we[d]), .d(cpu_wdata), .q(dev_q[d])
    );
  end

  mmio_rdata_mux #(.DATA_W(DATA_W)) u_mux (
    .src(src), .mem_d(mem_rd), .dev1_d(dev_q[0]), .dev2_d(dev_q[1]),
    .y(cpu_rdata)
  );

  assign rd_sel = src;
  assign dev1_q = dev_q[0];
  assign dev2_q = dev_q[1];

  // R9: write enables are mutually exclusive
  a_r9_one_target: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_we, dev_we}));
  // R6: select code 11 never leaves the decoder
  a_r6_sel_legal: assert property (@(posedge clk) disable iff (!rst_n)
    rd_sel != 2'b11);
  // R7: a load from device one's word returns its register
  a_r7_dev1_read: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr == DEV1_ADDR) |-> (cpu_rdata == dev1_q));
  // R2: a store to device one's word reaches only device one
  a_r2_dev1_store: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_we && cpu_addr == DEV1_ADDR) |=> (dev1_q == $past(cpu_wdata)) && $stable(dev2_q));
  // R4: a store elsewhere leaves both device registers alone
  a_r4_mem_store: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_we && cpu_addr != DEV1_ADDR && cpu_addr != DEV2_ADDR)
      |=> $stable(dev1_q) && $stable(dev2_q));
endmodule

// File: tb/test_mmio_bridge.sv
module test_mmio_bridge;
  localparam logic [31:0] A_DEV1 = 32'hFFFF_FFF4;
  localparam logic [31:0] A_DEV2 = 32'hFFFF_FFF8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] cpu_addr = '0;
  logic        cpu_we = 1'b0;
  logic [31:0] cpu_wdata = '0;
  logic [31:0] cpu_rdata;
  logic [1:0]  rd_sel;
  logic [31:0] dev1_q, dev2_q;

  int n_checks = 0;
  int n_fails  = 0;

  typedef struct {
    logic [31:0] exp_data;
    logic [1:0]  exp_sel;
    string       tag;
  } load_item_t;
  load_item_t sbq[$];

  always #2.5 clk = ~clk;

  mmio_bridge i_mmio_bridge (
    .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_we(cpu_we),
    .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .rd_sel(rd_sel),
    .dev1_q(dev1_q), .dev2_q(dev2_q)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_store(input logic [31:0] a, input logic [31:0] d, input logic we);
    @(negedge clk);
    cpu_addr = a; cpu_wdata = d; cpu_we = we;
    @(negedge clk);
    cpu_we = 1'b0;
  endtask

  task automatic do_load(input logic [31:0] a, input logic [31:0] exp,
                         input logic [1:0] sel, input string tag);
    load_item_t it;
    @(negedge clk);
    cpu_addr = a; cpu_we = 1'b0;
    it.exp_data = exp; it.exp_sel = sel; it.tag = tag;
    sbq.push_back(it);
  endtask

  task automatic check_devs(input logic [31:0] e1, input logic [31:0] e2, input string tag);
    @(negedge clk);
    #2;
    check(dev1_q, e1, {tag, " dev1"});
    check(dev2_q, e2, {tag, " dev2"});
  endtask

  initial begin : monitor
    load_item_t it;
    forever begin
      @(negedge clk);
      #2;
      if (sbq.size() != 0) begin
        it = sbq.pop_front();
        check(cpu_rdata, it.exp_data, {it.tag, " data"});
        check({30'd0, rd_sel}, {30'd0, it.exp_sel}, {it.tag, " sel"});
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_checks++; n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    #2;
    check(dev1_q, 32'h0, "R1 dev1 in reset");
    check(dev2_q, 32'h0, "R1 dev2 in reset");
    @(negedge clk);
    rst_n = 1'b1;
    do_load(A_DEV1, 32'h0, 2'b01, "R1 dev1 after reset");
    do_load(A_DEV2, 32'h0, 2'b10, "R1 dev2 after reset");

    // Pre-load the memory words the device addresses alias onto (61, 62)
    do_store(32'h0000_00F4, 32'hAAAA_0001, 1'b1);
    do_store(32'h0000_00F8, 32'hBBBB_0002, 1'b1);
    do_store(32'h0000_0004, 32'h1111_1111, 1'b1);
    check_devs(32'h0, 32'h0, "R4 mem store keeps devs");

    do_store(A_DEV1, 32'd42, 1'b1);
    check_devs(32'd42, 32'h0, "R2 dev1 store");
    do_store(A_DEV2, 32'hCAFE_F00D, 1'b1);
    check_devs(32'd42, 32'hCAFE_F00D, "R3 dev2 store");

    do_load(32'h0000_00F4, 32'hAAAA_0001, 2'b00, "R2 memory untouched");
    do_load(32'h0000_00F8, 32'hBBBB_0002, 2'b00, "R3 memory untouched");
    do_load(A_DEV1, 32'd42, 2'b01, "R6 R7 dev1 load");
    do_load(A_DEV2, 32'hCAFE_F00D, 2'b10, "R6 R7 dev2 load");
    do_load(32'h0000_0004, 32'h1111_1111, 2'b00, "R7 mem load");
    do_load(32'h0000_0104, 32'h1111_1111, 2'b00, "R8 alias 0x104");
    do_load(32'h0000_0007, 32'h1111_1111, 2'b00, "R8 byte offset ignored");

    // R5: strobe low changes nothing
    do_store(A_DEV1, 32'hDEAD_BEEF, 1'b0);
    do_store(A_DEV2, 32'hDEAD_BEEF, 1'b0);
    do_store(32'h0000_0004, 32'hDEAD_BEEF, 1'b0);
    check_devs(32'd42, 32'hCAFE_F00D, "R5 no strobe devs");
    do_load(32'h0000_0004, 32'h1111_1111, 2'b00, "R5 no strobe mem");

    // Near-miss address just above device two is plain memory
    do_store(32'hFFFF_FFFC, 32'h5A5A_0063, 1'b1);
    check_devs(32'd42, 32'hCAFE_F00D, "R4 near-miss keeps devs");
    do_load(32'hFFFF_FFFC, 32'h5A5A_0063, 2'b00, "R6 near-miss sel mem");
    do_load(32'h0000_00FC, 32'h5A5A_0063, 2'b00, "R8 near-miss alias");

    do_store(32'h0000_0108, 32'h0808_0808, 1'b1);
    do_load(32'h0000_0008, 32'h0808_0808, 2'b00, "R8 store alias");

    for (int i = 16; i < 32; i++)
      do_store(32'(i * 4), 32'h3C00_0000 + 32'(i * 7), 1'b1);
    for (int i = 16; i < 32; i++)
      do_load(32'(i * 4), 32'h3C00_0000 + 32'(i * 7), 2'b00, "R4 pattern readback");

    do_store(A_DEV1, 32'h0123_4567, 1'b1);
    do_store(A_DEV1, 32'h89AB_CDEF, 1'b1);
    check_devs(32'h89AB_CDEF, 32'hCAFE_F00D, "R2 last store wins");

    repeat (3) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule